// File: doc/BRIEF.md
# Receive Packet Acceptance Filter

This block sits in the receive path of a serial-bus link layer. As each packet arrives as a stream of 32-bit quadlets, the block decides three things. It decides whether the packet goes into the general receive FIFO, how many of its quadlets are written, and which acknowledge the node returns. The decision is made on the header quadlet. It uses the packet kind, the destination node number, the FIFO-full flag and a small set of mode bits. It is then held for the rest of the packet.

Self-identification bursts collected during bus initialisation are stored as one packet. Each two-quadlet entry in the burst is checked: its second quadlet must be the bitwise complement of its first. Each entry is tagged with a 4-bit status code. Link-on and PHY-configuration packets are cut down to their first quadlet. Asynchronous packets addressed to this node end with an acknowledge pulse that reports either complete or busy. All outputs are registered and appear one cycle after the quadlet that causes them.

Top module: `rxf_accept_filter`

## Requirements
- R1: An asynchronous packet (kind 0) is stored when its 6-bit destination is 63 (broadcast), whatever the ID-valid bit says. A packet addressed to `nodeNum` is stored only while `ctlIdValid` is 1. Any other destination is rejected. Each stored quadlet appears on `fifoWe`/`fifoData` one cycle after it is presented.
- R2: The asynchronous receive enable resets to 0. It is loaded from `asyncEnD` when `asyncEnWe` is 1 and cleared by `busReset`, and `busReset` wins when both occur in the same cycle. The enable is visible on `asyncEnQ` one cycle later. While it is 0, asynchronous packets are neither stored nor acknowledged.
- R3: A non-broadcast asynchronous packet that is accepted by address gets one `ackValid` pulse, one cycle after its last quadlet. `ackBusy` is 1 when `ctlBusyForce` is 1 or when `fifoFull` was 1 at the header, and in that case nothing of the packet is stored. Otherwise `ackBusy` is 0. Broadcast packets get no acknowledge.
- R4: An isochronous packet (kind 1) is stored only when `ctlIsoAll` and `ctlIsoRxEn` are both 1.
- R5: A cycle-start packet (kind 2) is stored when `ctlCycleStartRx` is 1 and rejected otherwise.
- R6: A self-ID burst (kind 3) is stored whole when `ctlSelfIdRx` is 1 and rejected otherwise.
- R7: In a stored self-ID burst, the quadlets form pairs. On the second quadlet of each pair, `statusValid` pulses one cycle later. `statusCode` is 4'h1 when that quadlet equals the bitwise inverse of the first, and 4'hD otherwise. A bad pair is still stored.
- R8: When a stored self-ID burst ends on the first quadlet of a pair, that unpaired quadlet is stored and reported with status 4'hD.
- R9: Link-on (kind 4) and PHY-configuration (kind 5) packets are accepted only when `ctlSelfIdRx` is 1. Only their first quadlet is stored.
- R10: A rejected packet causes no FIFO write at all, including its header. `dropPulse` goes high for one cycle, one cycle after the header. This includes the busy case of R3.
- R11: When `fifoFull` is 1 at the header, the packet is rejected whatever its kind. A broadcast asynchronous packet in this case gets no acknowledge.
- R12: After reset, `fifoWe`, `ackValid`, `ackBusy`, `statusValid`, `statusCode`, `dropPulse` and `asyncEnQ` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlIdValid | input | 1 | Accept packets addressed to own node number |
| ctlSelfIdRx | input | 1 | Store self-ID, link-on and PHY-configuration packets |
| ctlBusyForce | input | 1 | Answer every addressed non-broadcast async packet with busy |
| ctlIsoAll | input | 1 | Receive all isochronous packets |
| ctlIsoRxEn | input | 1 | Isochronous receive enable |
| ctlCycleStartRx | input | 1 | Store cycle-start packets |
| asyncEnWe | input | 1 | Write strobe for the async receive enable |
| asyncEnD | input | 1 | Value written to the async receive enable |
| busReset | input | 1 | Bus reset; clears the async receive enable |
| nodeNum | input | 6 | Own node number |
| pktStart | input | 1 | Current quadlet is a packet header |
| pktKind | input | 3 | Packet kind, valid with pktStart (0 async, 1 iso, 2 cycle start, 3 self-ID, 4 link-on, 5 PHY config) |
| pktDest | input | 6 | Destination node number, valid with pktStart |
| qValid | input | 1 | Quadlet valid |
| qData | input | 32 | Quadlet data |
| qLast | input | 1 | Current quadlet ends the packet |
| fifoFull | input | 1 | Receive FIFO full |
| fifoWe | output | 1 | FIFO write strobe |
| fifoData | output | 32 | FIFO write data |
| ackValid | output | 1 | Acknowledge issued |
| ackBusy | output | 1 | Acknowledge is busy (1) or complete (0) |
| statusValid | output | 1 | Self-ID pair status issued |
| statusCode | output | 4 | 4'h1 good, 4'hD bad |
| dropPulse | output | 1 | Packet rejected |
| asyncEnQ | output | 1 | Current async receive enable |

## Verification
Two things can happen in the same cycle here. A write to the async receive enable can coincide with a bus reset, and the reset must win. The bench first raises the enable. It then drives `asyncEnWe` with value 1 together with `busReset` on one clock. It reads `asyncEnQ` afterwards, and finally sends a packet addressed to the node, which must be dropped with no acknowledge. The reverse order, a write one cycle after the reset, must leave the enable set. A second pairing is a header that is also the last quadlet. It is provoked with single-quadlet packets, and the acknowledge and write are judged against the scoreboard on the following cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [2:0] {
    KIND_ASYNC  = 3'd0,
    KIND_ISO    = 3'd1,
    KIND_CYC    = 3'd2,
    KIND_SELFID = 3'd3,
    KIND_LINKON = 3'd4,
    KIND_PHYCFG = 3'd5
  } pktKindE;

  localparam logic [3:0] ST_GOOD = 4'h1;
  localparam logic [3:0] ST_BAD  = 4'hD;

  typedef struct packed {
    logic wr;         // write this quadlet to the FIFO
    logic capFirst;   // remember as first quadlet of a self-ID pair
    logic checkPair;  // compare against remembered first quadlet
    logic flushOdd;   // unpaired trailing self-ID quadlet
  } dpStrobeT;

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int NODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlIdValid,
  input  logic              ctlSelfIdRx,
  input  logic              ctlBusyForce,
  input  logic              ctlIsoAll,
  input  logic              ctlIsoRxEn,
  input  logic              ctlCycleStartRx,
  input  logic              asyncEnWe,
  input  logic              asyncEnD,
  input  logic              busReset,
  input  logic [NODE_W-1:0] nodeNum,
  input  logic              pktStart,
  input  logic [2:0]        pktKind,
  input  logic [NODE_W-1:0] pktDest,
  input  logic              qValid,
  input  logic              qLast,
  input  logic              fifoFull,
  output dpStrobeT          strobe,
  output logic              ackValid,
  output logic              ackBusy,
  output logic              dropPulse,
  output logic              asyncEnQ
);

  localparam logic [NODE_W-1:0] BCAST = {NODE_W{1'b1}};

  pktKindE kind;
  logic isBcast, ownAddr, nonBcastOwn;
  logic dKeep, dFirstOnly, dSelf, dAckDue, dAckBusy;
  logic keepQ, firstOnlyQ, selfQ, ackDueQ, ackBusyQ, phaseQ;
  logic curKeep, curFirstOnly, curSelf, curAckDue, curAckBusy, curPhase;

  assign kind        = pktKindE'(pktKind);
  assign isBcast     = (pktDest == BCAST);
  assign ownAddr     = ctlIdValid && (pktDest == nodeNum);
  assign nonBcastOwn = ownAddr && !isBcast;

  // Header decision
  always_comb begin
    dKeep      = 1'b0;
    dFirstOnly = 1'b0;
    dSelf      = 1'b0;
    dAckDue    = 1'b0;
    dAckBusy   = 1'b0;
    unique case (kind)
      KIND_ASYNC: begin
        dKeep    = asyncEnQ && (isBcast || ownAddr) && !fifoFull
                   && !(nonBcastOwn && ctlBusyForce);
        dAckDue  = asyncEnQ && nonBcastOwn;
        dAckBusy = ctlBusyForce || fifoFull;
      end
      KIND_ISO:    dKeep = ctlIsoAll && ctlIsoRxEn && !fifoFull;
      KIND_CYC:    dKeep = ctlCycleStartRx && !fifoFull;
      KIND_SELFID: begin
        dKeep = ctlSelfIdRx && !fifoFull;
        dSelf = 1'b1;
      end
      KIND_LINKON, KIND_PHYCFG: begin
        dKeep      = ctlSelfIdRx && !fifoFull;
        dFirstOnly = 1'b1;
      end
      default: dKeep = 1'b0;
    endcase
  end

  // Header cycle uses the fresh decision, later quadlets the held one
  assign curKeep      = pktStart ? dKeep      : keepQ;
  assign curFirstOnly = pktStart ? dFirstOnly : firstOnlyQ;
  assign curSelf      = pktStart ? dSelf      : selfQ;
  assign curAckDue    = pktStart ? dAckDue    : ackDueQ;
  assign curAckBusy   = pktStart ? dAckBusy   : ackBusyQ;
  assign curPhase     = pktStart ? 1'b0       : phaseQ;

  always_comb begin
    strobe.wr        = qValid && curKeep && (!curFirstOnly || pktStart);
    strobe.capFirst  = qValid && curKeep && curSelf && !curPhase;
    strobe.checkPair = qValid && curKeep && curSelf && curPhase;
    strobe.flushOdd  = qValid && curKeep && curSelf && !curPhase && qLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keepQ      <= 1'b0;
      firstOnlyQ <= 1'b0;
      selfQ      <= 1'b0;
      ackDueQ    <= 1'b0;
      ackBusyQ   <= 1'b0;
      phaseQ     <= 1'b0;
      ackValid   <= 1'b0;
      ackBusy    <= 1'b0;
      dropPulse  <= 1'b0;
      asyncEnQ   <= 1'b0;
    end else begin
      if (busReset)       asyncEnQ <= 1'b0;
      else if (asyncEnWe) asyncEnQ <= asyncEnD;

      ackValid  <= qValid && qLast && curAckDue;
      ackBusy   <= qValid && qLast && curAckDue && curAckBusy;
      dropPulse <= qValid && pktStart && !dKeep;

      if (qValid) begin
        keepQ      <= curKeep && !qLast;
        firstOnlyQ <= curFirstOnly;
        selfQ      <= curSelf;
        ackDueQ    <= curAckDue && !qLast;
        ackBusyQ   <= curAckBusy;
        phaseQ     <= curSelf && !curPhase;
      end
    end
  end

endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int QUAD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [QUAD_W-1:0] qData,
  output logic              fifoWe,
  output logic [QUAD_W-1:0] fifoData,
  output logic              statusValid,
  output logic [3:0]        statusCode
);

  logic [QUAD_W-1:0] firstQ;
  logic              pairGood;

  assign pairGood = (qData == ~firstQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWe      <= 1'b0;
      fifoData    <= '0;
      firstQ      <= '0;
      statusValid <= 1'b0;
      statusCode  <= 4'h0;
    end else begin
      fifoWe <= strobe.wr;
      if (strobe.wr)       fifoData <= qData;
      if (strobe.capFirst) firstQ   <= qData;
      statusValid <= strobe.checkPair || strobe.flushOdd;
      if (strobe.checkPair)     statusCode <= pairGood ? ST_GOOD : ST_BAD;
      else if (strobe.flushOdd) statusCode <= ST_BAD;
      else                      statusCode <= 4'h0;
    end
  end

endmodule

// File: rtl/rxf_accept_filter.sv
module rxf_accept_filter
  import rxf_pkg::*;
#(
  parameter int NODE_W = 6,
  parameter int QUAD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlIdValid,
  input  logic              ctlSelfIdRx,
  input  logic              ctlBusyForce,
  input  logic              ctlIsoAll,
  input  logic              ctlIsoRxEn,
  input  logic              ctlCycleStartRx,
  input  logic              asyncEnWe,
  input  logic              asyncEnD,
  input  logic              busReset,
  input  logic [NODE_W-1:0] nodeNum,
  input  logic              pktStart,
  input  logic [2:0]        pktKind,
  input  logic [NODE_W-1:0] pktDest,
  input  logic              qValid,
  input  logic [QUAD_W-1:0] qData,
  input  logic              qLast,
  input  logic              fifoFull,
  output logic              fifoWe,
  output logic [QUAD_W-1:0] fifoData,
  output logic              ackValid,
  output logic              ackBusy,
  output logic              statusValid,
  output logic [3:0]        statusCode,
  output logic              dropPulse,
  output logic              asyncEnQ
);

  dpStrobeT strobe;

  rxf_ctrl #(.NODE_W(NODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctlIdValid(ctlIdValid), .ctlSelfIdRx(ctlSelfIdRx),
    .ctlBusyForce(ctlBusyForce), .ctlIsoAll(ctlIsoAll),
    .ctlIsoRxEn(ctlIsoRxEn), .ctlCycleStartRx(ctlCycleStartRx),
    .asyncEnWe(asyncEnWe), .asyncEnD(asyncEnD), .busReset(busReset),
    .nodeNum(nodeNum), .pktStart(pktStart), .pktKind(pktKind),
    .pktDest(pktDest), .qValid(qValid), .qLast(qLast),
    .fifoFull(fifoFull), .strobe(strobe), .ackValid(ackValid),
    .ackBusy(ackBusy), .dropPulse(dropPulse), .asyncEnQ(asyncEnQ)
  );

  rxf_datapath #(.QUAD_W(QUAD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .qData(qData),
    .fifoWe(fifoWe), .fifoData(fifoData),
    .statusValid(statusValid), .statusCode(statusCode)
  );

endmodule

// File: rtl/rxf_accept_filter_chk.sv
module rxf_accept_filter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busReset,
  input logic       qValid,
  input logic       fifoWe,
  input logic       ackValid,
  input logic       ackBusy,
  input logic       statusValid,
  input logic [3:0] statusCode,
  input logic       dropPulse,
  input logic       asyncEnQ
);

  // R10: a rejected header never produces a write in the same slot
  p_drop_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    dropPulse |-> !fifoWe);

  // R3: busy acknowledge means the last quadlet was not stored
  p_busy_no_store_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackBusy) |-> !fifoWe);

  // R3: complete acknowledge means the last quadlet was stored
  p_complete_stored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !ackBusy) |-> fifoWe);

  // R7: only the two defined codes are ever reported
  p_status_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> (statusCode == 4'h1 || statusCode == 4'hD));

  // R7: every status belongs to a quadlet that was written
  p_status_with_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> fifoWe);

  // R2: bus reset clears the async receive enable
  p_busreset_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !asyncEnQ);

  // R1: a write needs a quadlet presented the cycle before
  p_write_needs_input_r1: assert property (@(posedge clk) disable iff (!rstN)
    fifoWe |-> $past(qValid));

endmodule

bind rxf_accept_filter rxf_accept_filter_chk u_chk (.*);

// File: tb/rxf_accept_filter_tb.sv
module rxf_accept_filter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlIdValid = 0, ctlSelfIdRx = 0, ctlBusyForce = 0;
  logic        ctlIsoAll = 0, ctlIsoRxEn = 0, ctlCycleStartRx = 0;
  logic        asyncEnWe = 0, asyncEnD = 0, busReset = 0;
  logic [5:0]  nodeNum = 6'd5;
  logic        pktStart = 0;
  logic [2:0]  pktKind = 0;
  logic [5:0]  pktDest = 0;
  logic        qValid = 0, qLast = 0, fifoFull = 0;
  logic [31:0] qData = 0;
  logic        fifoWe, ackValid, ackBusy, statusValid, dropPulse, asyncEnQ;
  logic [31:0] fifoData;
  logic [3:0]  statusCode;

  int errors = 0;
  int checks = 0;
  int dropSeen = 0;
  bit finished = 0;

  logic [31:0] expW[$];  string tagW[$];
  logic        expA[$];  string tagA[$];
  logic [3:0]  expS[$];  string tagS[$];
  logic [31:0] pk [0:3];

  always #4 clk = ~clk;  // 125 MHz

  rxf_accept_filter u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops scoreboard entries as outputs appear
  always @(negedge clk) begin
    if (rstN) begin
      if (fifoWe) begin
        if (expW.size() == 0) chk(0, "R10 unexpected write", fifoData, 0);
        else begin
          automatic logic [31:0] e = expW.pop_front();
          automatic string t = tagW.pop_front();
          chk(fifoData == e, t, fifoData, e);
        end
      end
      if (ackValid) begin
        if (expA.size() == 0) chk(0, "R3 unexpected ack", ackBusy, 0);
        else begin
          automatic logic e = expA.pop_front();
          automatic string t = tagA.pop_front();
          chk(ackBusy == e, t, ackBusy, e);
        end
      end
      if (statusValid) begin
        if (expS.size() == 0) chk(0, "R7 unexpected status", statusCode, 0);
        else begin
          automatic logic [3:0] e = expS.pop_front();
          automatic string t = tagS.pop_front();
          chk(statusCode == e, t, statusCode, e);
        end
      end
      if (dropPulse) dropSeen++;
    end
  end

  task automatic pushW(input logic [31:0] d, input string t);
    expW.push_back(d); tagW.push_back(t);
  endtask
  task automatic pushA(input logic b, input string t);
    expA.push_back(b); tagA.push_back(t);
  endtask
  task automatic pushS(input logic [3:0] c, input string t);
    expS.push_back(c); tagS.push_back(t);
  endtask

  task automatic send(input logic [2:0] kind, input logic [5:0] dest, input int n);
    dropSeen = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      qValid = 1; pktStart = (i == 0); qLast = (i == n - 1);
      qData = pk[i]; pktKind = kind; pktDest = dest;
    end
    @(posedge clk); #1;
    qValid = 0; pktStart = 0; qLast = 0;
  endtask

  // After each packet: all expected items consumed, drop count as expected
  task automatic settle(input string tag, input int expDrop);
    repeat (3) @(posedge clk);
    #1;
    chk(expW.size() == 0 && expA.size() == 0 && expS.size() == 0,
        {tag, " missing output"}, expW.size() + expA.size() + expS.size(), 0);
    chk(dropSeen == expDrop, {tag, " drop count"}, dropSeen, expDrop);
  endtask

  task automatic setEn(input logic v);
    @(posedge clk); #1; asyncEnWe = 1; asyncEnD = v;
    @(posedge clk); #1; asyncEnWe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    pk[0] = 32'hA5A5_0001; pk[1] = 32'h1234_5678;
    pk[2] = 32'hCAFE_0003; pk[3] = 32'h0F0F_F0F0;
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    chk({fifoWe, ackValid, ackBusy, statusValid, statusCode, dropPulse, asyncEnQ} == 0,
        "R12 reset outputs", {fifoWe, ackValid, statusValid, dropPulse, asyncEnQ}, 0);
    @(posedge clk); #1; rstN = 1;

    // R2: async disabled after reset -> own packet dropped, no ack
    ctlIdValid = 1;
    send(3'd0, 6'd5, 2); settle("R2 disabled", 1);

    setEn(1);
    @(negedge clk); chk(asyncEnQ == 1, "R2 enable write", asyncEnQ, 1);

    // R1/R3: own address, three quadlets, complete ack
    for (int i = 0; i < 3; i++) pushW(pk[i], "R1 own stored");
    pushA(0, "R3 complete ack");
    send(3'd0, 6'd5, 3); settle("R1 own", 0);

    // R3: single-quadlet packet, header and last together
    pushW(pk[0], "R1 single stored"); pushA(0, "R3 single ack");
    send(3'd0, 6'd5, 1); settle("R3 single", 0);

    // R1: ID-valid clear -> own dropped, broadcast kept
    ctlIdValid = 0;
    send(3'd0, 6'd5, 2); settle("R1 idvalid clear", 1);
    pushW(pk[0], "R1 bcast"); pushW(pk[1], "R1 bcast");
    send(3'd0, 6'd63, 2); settle("R1 bcast", 0);
    ctlIdValid = 1;
    send(3'd0, 6'd9, 2); settle("R1 other dest", 1);

    // R3: forced busy
    ctlBusyForce = 1;
    pushA(1, "R3 forced busy");
    send(3'd0, 6'd5, 2); settle("R3 forced busy", 1);
    pushW(pk[0], "R3 bcast under busy");
    send(3'd0, 6'd63, 1); settle("R3 bcast under busy", 0);
    ctlBusyForce = 0;

    // R3/R11: FIFO full
    fifoFull = 1;
    pushA(1, "R3 full busy");
    send(3'd0, 6'd5, 2); settle("R3 full busy", 1);
    ctlIsoAll = 1; ctlIsoRxEn = 1;
    send(3'd1, 6'd0, 2); settle("R11 iso full", 1);
    send(3'd0, 6'd63, 1); settle("R11 bcast full", 1);
    fifoFull = 0;

    // R4
    ctlIsoRxEn = 0;
    send(3'd1, 6'd0, 2); settle("R4 iso en off", 1);
    ctlIsoRxEn = 1;
    pushW(pk[0], "R4 iso"); pushW(pk[1], "R4 iso");
    send(3'd1, 6'd0, 2); settle("R4 iso on", 0);

    // R5
    send(3'd2, 6'd63, 2); settle("R5 cyc off", 1);
    ctlCycleStartRx = 1;
    pushW(pk[0], "R5 cyc"); pushW(pk[1], "R5 cyc");
    send(3'd2, 6'd63, 2); settle("R5 cyc on", 0);

    // R6/R7: self-ID burst, good pair then bad pair
    pk[1] = ~pk[0]; pk[3] = pk[2] ^ 32'h1;
    send(3'd3, 6'd63, 4); settle("R6 selfid off", 1);
    ctlSelfIdRx = 1;
    for (int i = 0; i < 4; i++) pushW(pk[i], "R6 selfid stored");
    pushS(4'h1, "R7 good pair"); pushS(4'hD, "R7 bad pair");
    send(3'd3, 6'd63, 4); settle("R7 selfid", 0);

    // R8: trailing unpaired quadlet
    for (int i = 0; i < 3; i++) pushW(pk[i], "R8 selfid stored");
    pushS(4'h1, "R8 first pair"); pushS(4'hD, "R8 unpaired");
    send(3'd3, 6'd63, 3); settle("R8 odd", 0);

    // R9: link-on and PHY config keep only the first quadlet
    pushW(pk[0], "R9 linkon first");
    send(3'd4, 6'd63, 3); settle("R9 linkon", 0);
    pushW(pk[0], "R9 phycfg first");
    send(3'd5, 6'd63, 2); settle("R9 phycfg", 0);
    ctlSelfIdRx = 0;
    send(3'd4, 6'd63, 2); settle("R9 linkon off", 1);

    // R2: bus reset and enable write in the same cycle; reset wins
    @(posedge clk); #1; asyncEnWe = 1; asyncEnD = 1; busReset = 1;
    @(posedge clk); #1; asyncEnWe = 0; busReset = 0;
    @(negedge clk); chk(asyncEnQ == 0, "R2 reset beats write", asyncEnQ, 0);
    send(3'd0, 6'd5, 2); settle("R2 after bus reset", 1);
    // write the cycle after a reset: enable set
    @(posedge clk); #1; busReset = 1;
    @(posedge clk); #1; busReset = 0; asyncEnWe = 1; asyncEnD = 1;
    @(posedge clk); #1; asyncEnWe = 0;
    @(negedge clk); chk(asyncEnQ == 1, "R2 write after reset", asyncEnQ, 1);
    setEn(0);
    send(3'd0, 6'd63, 1); settle("R2 written off", 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule